// File: doc/BRIEF.md
# NAND Spare Buffer Address Mapper

This block turns a byte access request, given as a column and a length, into the stream of physical buffer addresses that a NAND controller's internal page memory needs. The page memory has a main area that mirrors the data bytes of a flash page. Next to it sit a number of small spare buffers, placed at a fixed stride above a spare base address. A flash page is viewed as a run of 512-byte chunks. Each chunk's portion of the out-of-band bytes sits at the start of its own spare buffer. Because of that layout, a linear spare offset is not a flat address, and the mapper has to work out which buffer holds a byte and where in that buffer it sits.

Configuration is sampled together with a one-cycle start strobe:
- the page size, as a code,
- the spare size in bytes,
- a spare-only mode flag.

The block then issues one address per cycle with a valid strobe. It pulses a done flag once the last byte has been issued. A main-area access that runs into the end of the page carries on into spare space at spare offset 0. A column at or beyond the page size is itself a spare access.

Top module: `nsm_spare_mapper`

## Requirements
- R1: After reset, `busy_o`, `addr_vld_o` and `done_o` are all low.
- R2: A main access (spare-only low and column below the page size) issues `MAIN_BASE + column`, then consecutive addresses, one per cycle. The first of them appears in the cycle after start is sampled.
- R3: A main access that reaches the page size stops at the last main byte. It resumes after a gap of at least one cycle at spare offset 0, which is buffer 0, inner offset 0.
- R4: With spare-only low, a column at or above the page size starts a spare access at spare offset column − page size. The page size is 512 << page code, with code 0..3.
- R5: With spare-only high, the column is used directly as the spare offset, whatever its value.
- R6: Share = (spare size >> page code) with bit 0 cleared. Spare offset s lands in buffer min(s / share, last). Its inner offset is s − buffer × share. Its address is `SPARE_BASE + buffer × STRIDE + inner` (defaults 0x1000 and 0x40). When the share is 0, every spare byte goes to the last buffer.
- R7: When an access crosses a share boundary in any buffer below the last, the next address is inner offset 0 of the next buffer.
- R8: The last used buffer is index min(chunks, NBUF) − 1, where chunks = 1 << page code. It takes every byte past the even-rounded shares, at increasing inner offsets.
- R9: `done_o` is high for exactly one cycle per accepted start. That cycle is the one after the final address. A zero-length start gives done in the next cycle and no address.
- R10: A start that arrives while `busy_o` is high is ignored.
- R11: `addr_vld_o` is high only while `busy_o` is high. An accepted start issues exactly as many addresses as its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request strobe, sampled when idle |
| page_sel_i | input | 2 | Page size code: 512 << code bytes |
| spare_size_i | input | 9 | Spare bytes per page |
| spare_only_i | input | 1 | Treat the column as a spare offset |
| column_i | input | 13 | Starting column of the access |
| length_i | input | 13 | Number of bytes to address |
| addr_o | output | 13 | Physical byte address in page memory |
| addr_vld_o | output | 1 | `addr_o` is valid this cycle |
| busy_o | output | 1 | An access is in progress |
| done_o | output | 1 | One-cycle pulse after the last address |

## Verification
On every cycle the assertions check three kinds of local rule. Main addresses step by exactly one. Every spare address lands inside the spare window. A jump between spare addresses lands on inner offset 0 of the next buffer. They also check that done never overlaps a valid address and that busy only rises from a start. Whether the buffer chosen for a given offset, share and remainder is the right one cannot be seen one cycle at a time. Nor can the exact address count per request, or the fact that a start during an access leaves no trace. The scoreboard scenarios cover these: different page codes, odd spare sizes, a zero share, page-end spill-over and mid-access starts.

// File: rtl/nsm_pkg.sv
package nsm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_MAIN  = 2'd1,
      ST_SEEK  = 2'd2,
      ST_SPARE = 2'd3
   } nsm_state_e;
endpackage

// File: rtl/nsm_geom.sv
// Derives the per-buffer share and the index of the last used buffer
// from the latched page code and spare size.
module nsm_geom #(
   parameter int SEL_W = 2,
   parameter int SPR_W = 9,
   parameter int NBUF  = 8,
   localparam int IDX_W = $clog2(NBUF)
) (
   input  logic [SEL_W-1:0] sel_i,
   input  logic [SPR_W-1:0] spare_i,
   output logic [SPR_W-1:0] share_o,
   output logic [IDX_W-1:0] last_o
);
   localparam int MAX_LOG    = (1 << SEL_W) - 1;
   localparam int MAX_CHUNKS = 1 << MAX_LOG;
   localparam int CHK_W      = MAX_LOG + 1;

   logic [SPR_W-1:0] shifted;
   logic [CHK_W-1:0] chunks_m1;

   always_comb begin
      shifted   = spare_i >> sel_i;
      share_o   = {shifted[SPR_W-1:1], 1'b0};
      chunks_m1 = (CHK_W'(1) << sel_i) - CHK_W'(1);
   end

   generate
      if (NBUF >= MAX_CHUNKS) begin : g_direct
         // every chunk has a buffer of its own
         assign last_o = IDX_W'(chunks_m1);
      end else begin : g_clamp
         // more chunks than buffers: the top buffer absorbs the rest
         assign last_o = (chunks_m1 > CHK_W'(NBUF - 1)) ? IDX_W'(NBUF - 1)
                                                         : IDX_W'(chunks_m1);
      end
   endgenerate
endmodule

// File: rtl/nsm_walker.sv
// Sequencer: main phase, seek to the starting buffer, spare phase.
module nsm_walker
   import nsm_pkg::*;
#(
   parameter int SEL_W       = 2,
   parameter int SPR_W       = 9,
   parameter int COL_W       = 13,
   parameter int LEN_W       = 13,
   parameter int NBUF        = 8,
   parameter int CHUNK_BYTES = 512,
   localparam int IDX_W = $clog2(NBUF)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic [SPR_W-1:0] spare_i,
   input  logic             spare_only_i,
   input  logic [COL_W-1:0] col_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic [SPR_W-1:0] share_i,
   input  logic [IDX_W-1:0] last_i,
   output logic [SEL_W-1:0] sel_q_o,
   output logic [SPR_W-1:0] spare_q_o,
   output logic             emit_o,
   output logic             in_spare_o,
   output logic [COL_W-1:0] col_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [COL_W-1:0] inner_o,
   output logic             busy_o,
   output logic             done_o
);
   nsm_state_e       state_q, state_n;
   logic [SEL_W-1:0] sel_q, sel_n;
   logic [SPR_W-1:0] spare_q, spare_n;
   logic [COL_W-1:0] col_q, col_n;
   logic [COL_W-1:0] off_q, off_n;
   logic [IDX_W-1:0] idx_q, idx_n;
   logic [LEN_W-1:0] rem_q, rem_n;
   logic             done_q, done_n;

   logic [COL_W-1:0] page_in, page_q, share_w;

   always_comb begin
      page_in = COL_W'(CHUNK_BYTES) << sel_i;
      page_q  = COL_W'(CHUNK_BYTES) << sel_q;
      share_w = COL_W'(share_i);
   end

   always_comb begin
      state_n = state_q;
      sel_n   = sel_q;
      spare_n = spare_q;
      col_n   = col_q;
      off_n   = off_q;
      idx_n   = idx_q;
      rem_n   = rem_q;
      done_n  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               sel_n   = sel_i;
               spare_n = spare_i;
               rem_n   = len_i;
               col_n   = col_i;
               idx_n   = '0;
               if (len_i == '0) begin
                  done_n = 1'b1;
               end else if (spare_only_i) begin
                  off_n   = col_i;
                  state_n = ST_SEEK;
               end else if (col_i >= page_in) begin
                  off_n   = col_i - page_in;
                  state_n = ST_SEEK;
               end else begin
                  state_n = ST_MAIN;
               end
            end
         end
         ST_MAIN: begin
            rem_n = rem_q - LEN_W'(1);
            col_n = col_q + COL_W'(1);
            if (rem_q == LEN_W'(1)) begin
               done_n  = 1'b1;
               state_n = ST_IDLE;
            end else if (col_q + COL_W'(1) == page_q) begin
               off_n   = '0;
               idx_n   = '0;
               state_n = ST_SEEK;
            end
         end
         ST_SEEK: begin
            if (idx_q < last_i && off_q >= share_w) begin
               off_n = off_q - share_w;
               idx_n = idx_q + IDX_W'(1);
            end else begin
               state_n = ST_SPARE;
            end
         end
         ST_SPARE: begin
            rem_n = rem_q - LEN_W'(1);
            if (rem_q == LEN_W'(1)) begin
               done_n  = 1'b1;
               state_n = ST_IDLE;
            end else if (idx_q < last_i && off_q + COL_W'(1) >= share_w) begin
               idx_n = idx_q + IDX_W'(1);
               off_n = '0;
            end else begin
               off_n = off_q + COL_W'(1);
            end
         end
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sel_q   <= '0;
         spare_q <= '0;
         col_q   <= '0;
         off_q   <= '0;
         idx_q   <= '0;
         rem_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_n;
         sel_q   <= sel_n;
         spare_q <= spare_n;
         col_q   <= col_n;
         off_q   <= off_n;
         idx_q   <= idx_n;
         rem_q   <= rem_n;
         done_q  <= done_n;
      end
   end

   always_comb begin
      sel_q_o    = sel_q;
      spare_q_o  = spare_q;
      emit_o     = (state_q == ST_MAIN) || (state_q == ST_SPARE);
      in_spare_o = (state_q == ST_SPARE);
      col_o      = col_q;
      idx_o      = idx_q;
      inner_o    = off_q;
      busy_o     = (state_q != ST_IDLE);
      done_o     = done_q;
   end
endmodule

// File: rtl/nsm_addr_fmt.sv
// Forms the physical page-memory address for main or spare bytes.
module nsm_addr_fmt #(
   parameter int ADDR_W     = 13,
   parameter int COL_W      = 13,
   parameter int NBUF       = 8,
   parameter int MAIN_BASE  = 0,
   parameter int SPARE_BASE = 'h1000,
   parameter int STRIDE     = 'h40,
   localparam int IDX_W = $clog2(NBUF)
) (
   input  logic              in_spare_i,
   input  logic [COL_W-1:0]  col_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [COL_W-1:0]  inner_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] buf_base;

   generate
      if ((STRIDE & (STRIDE - 1)) == 0) begin : g_shift
         localparam int STR_LOG = $clog2(STRIDE);
         assign buf_base = ADDR_W'(idx_i) << STR_LOG;
      end else begin : g_mult
         assign buf_base = ADDR_W'(idx_i) * ADDR_W'(STRIDE);
      end
   endgenerate

   always_comb begin
      if (in_spare_i)
         addr_o = ADDR_W'(SPARE_BASE) + buf_base + ADDR_W'(inner_i);
      else
         addr_o = ADDR_W'(MAIN_BASE) + ADDR_W'(col_i);
   end
endmodule

// File: rtl/nsm_spare_mapper.sv
module nsm_spare_mapper #(
   parameter int SEL_W       = 2,
   parameter int SPR_W       = 9,
   parameter int COL_W       = 13,
   parameter int LEN_W       = 13,
   parameter int ADDR_W      = 13,
   parameter int NBUF        = 8,
   parameter int CHUNK_BYTES = 512,
   parameter int MAIN_BASE   = 0,
   parameter int SPARE_BASE  = 'h1000,
   parameter int STRIDE      = 'h40,
   localparam int IDX_W = $clog2(NBUF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [SEL_W-1:0]  page_sel_i,
   input  logic [SPR_W-1:0]  spare_size_i,
   input  logic              spare_only_i,
   input  logic [COL_W-1:0]  column_i,
   input  logic [LEN_W-1:0]  length_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              addr_vld_o,
   output logic              busy_o,
   output logic              done_o
);
   if (NBUF < 2) begin : g_bad_nbuf
      $error("NBUF must be at least 2");
   end
   if (SPR_W > COL_W) begin : g_bad_spr
      $error("SPR_W must not exceed COL_W");
   end
   if (SPARE_BASE + NBUF * STRIDE > (1 << ADDR_W)) begin : g_bad_addr
      $error("spare window does not fit in ADDR_W");
   end
   if (MAIN_BASE + (CHUNK_BYTES << ((1 << SEL_W) - 1)) > SPARE_BASE) begin : g_bad_main
      $error("main area overlaps spare window");
   end

   logic [SEL_W-1:0] sel_q;
   logic [SPR_W-1:0] spare_q;
   logic [SPR_W-1:0] share;
   logic [IDX_W-1:0] last_idx;
   logic             emit, in_spare;
   logic [COL_W-1:0] col, inner;
   logic [IDX_W-1:0] idx;

   nsm_geom #(.SEL_W(SEL_W), .SPR_W(SPR_W), .NBUF(NBUF)) u_geom (
      .sel_i   (sel_q),
      .spare_i (spare_q),
      .share_o (share),
      .last_o  (last_idx)
   );

   nsm_walker #(
      .SEL_W(SEL_W), .SPR_W(SPR_W), .COL_W(COL_W), .LEN_W(LEN_W),
      .NBUF(NBUF), .CHUNK_BYTES(CHUNK_BYTES)
   ) u_walk (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .sel_i        (page_sel_i),
      .spare_i      (spare_size_i),
      .spare_only_i (spare_only_i),
      .col_i        (column_i),
      .len_i        (length_i),
      .share_i      (share),
      .last_i       (last_idx),
      .sel_q_o      (sel_q),
      .spare_q_o    (spare_q),
      .emit_o       (emit),
      .in_spare_o   (in_spare),
      .col_o        (col),
      .idx_o        (idx),
      .inner_o      (inner),
      .busy_o       (busy_o),
      .done_o       (done_o)
   );

   nsm_addr_fmt #(
      .ADDR_W(ADDR_W), .COL_W(COL_W), .NBUF(NBUF), .MAIN_BASE(MAIN_BASE),
      .SPARE_BASE(SPARE_BASE), .STRIDE(STRIDE)
   ) u_fmt (
      .in_spare_i (in_spare),
      .col_i      (col),
      .idx_i      (idx),
      .inner_i    (inner),
      .addr_o     (addr_o)
   );

   assign addr_vld_o = emit;
endmodule

// File: rtl/nsm_spare_mapper_chk.sv
module nsm_spare_mapper_chk #(
   parameter int ADDR_W     = 13,
   parameter int NBUF       = 8,
   parameter int SPARE_BASE = 'h1000,
   parameter int STRIDE     = 'h40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [ADDR_W-1:0] addr_o,
   input logic              addr_vld_o,
   input logic              busy_o,
   input logic              done_o
);
   localparam logic [ADDR_W-1:0] SB  = ADDR_W'(SPARE_BASE);
   localparam logic [ADDR_W-1:0] TOP = ADDR_W'(SPARE_BASE + NBUF * STRIDE);

   logic              is_sp;
   logic [ADDR_W-1:0] rel, rel_idx, rel_inner;

   always_comb begin
      is_sp     = addr_o >= SB;
      rel       = addr_o - SB;
      rel_idx   = rel / ADDR_W'(STRIDE);
      rel_inner = rel % ADDR_W'(STRIDE);
   end

   // R11: no address while idle
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !addr_vld_o);

   // R9: done follows the last address, never alongside one
   p_done_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!addr_vld_o && !busy_o));

   // R10: busy only rises out of an accepted start
   p_busy_from_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   // R2: main addresses step by one
   p_main_consec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld_o && $past(addr_vld_o) && !is_sp && ($past(addr_o) < SB))
      |-> (addr_o == $past(addr_o) + ADDR_W'(1)));

   // R6: spare addresses stay inside the spare window
   p_spare_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld_o && is_sp) |-> (addr_o < TOP));

   // R7: a jump between spare addresses opens the next buffer at offset 0
   p_buf_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld_o && $past(addr_vld_o) && is_sp && ($past(addr_o) >= SB)
       && (addr_o != $past(addr_o) + ADDR_W'(1)))
      |-> (rel_inner == '0 && rel_idx == $past(rel_idx) + ADDR_W'(1)));
endmodule

bind nsm_spare_mapper nsm_spare_mapper_chk #(
   .ADDR_W(ADDR_W), .NBUF(NBUF), .SPARE_BASE(SPARE_BASE), .STRIDE(STRIDE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .addr_o     (addr_o),
   .addr_vld_o (addr_vld_o),
   .busy_o     (busy_o),
   .done_o     (done_o)
);

// File: tb/nsm_spare_mapper_test.sv
`timescale 1ns/1ps
module nsm_spare_mapper_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  page_sel_i = '0;
   logic [8:0]  spare_size_i = '0;
   logic        spare_only_i = 1'b0;
   logic [12:0] column_i = '0;
   logic [12:0] length_i = '0;
   logic [12:0] addr_o;
   logic        addr_vld_o, busy_o, done_o;

   int tests = 0;
   int fails = 0;
   int done_cnt = 0;
   string cur_req = "R1";
   int exp_q[$];

   always #4 clk = ~clk;

   nsm_spare_mapper uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_sel_i(page_sel_i),
      .spare_size_i(spare_size_i), .spare_only_i(spare_only_i),
      .column_i(column_i), .length_i(length_i), .addr_o(addr_o),
      .addr_vld_o(addr_vld_o), .busy_o(busy_o), .done_o(done_o)
   );

   task automatic check(input string req, input int act, input int exp, input string what);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard as addresses appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (addr_vld_o) begin
            if (exp_q.size() == 0) begin
               check("R11", 1, 0, "unexpected address");
            end else begin
               int e;
               e = exp_q.pop_front();
               check(cur_req, int'(addr_o), e, "address");
            end
            check("R11", int'(busy_o), 1, "busy during address");
         end
         if (done_o) begin
            done_cnt++;
            check("R9", exp_q.size(), 0, "addresses left at done");
         end
      end
   end

   // driver: model the requirement and push the expected stream
   task automatic run(input string req, input int sel, input int spare, input bit so,
                      input int col, input int len, input bit poke);
      int page, share, chunks, last, s, c, d0, waited;
      bit in_main;
      page   = 512 << sel;
      share  = (spare >> sel) & ~1;
      chunks = 1 << sel;
      last   = ((chunks > 8) ? 8 : chunks) - 1;
      in_main = !so && (col < page);
      s = so ? col : ((col >= page) ? col - page : 0);
      c = col;
      for (int b = 0; b < len; b++) begin
         if (in_main) begin
            exp_q.push_back(c);
            c++;
            if (c == page) in_main = 1'b0;
         end else begin
            int idx, inner;
            idx = (share == 0) ? last : s / share;
            if (idx > last) idx = last;
            inner = s - idx * share;
            exp_q.push_back('h1000 + idx * 'h40 + inner);
            s++;
         end
      end
      cur_req = req;
      d0 = done_cnt;
      @(negedge clk);
      page_sel_i = 2'(sel); spare_size_i = 9'(spare); spare_only_i = so;
      column_i = 13'(col); length_i = 13'(len); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (poke) begin
         @(negedge clk);
         @(negedge clk);
         column_i = 13'(col + 7); length_i = 13'd3; start_i = 1'b1;   // R10
         @(negedge clk);
         start_i = 1'b0;
      end
      waited = 0;
      while (done_cnt == d0 && waited < 2000) begin
         @(negedge clk);
         waited++;
      end
      repeat (4) @(negedge clk);
      check("R9", done_cnt - d0, 1, "done pulses per start");
      check("R11", exp_q.size(), 0, "addresses missing");
      check("R11", int'(busy_o), 0, "busy after access");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL R9 watchdog: got no completion expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", int'(busy_o), 0, "busy in reset");
      check("R1", int'(addr_vld_o), 0, "valid in reset");
      check("R1", int'(done_o), 0, "done in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(busy_o), 0, "busy after reset");

      run("R2", 2, 64, 1'b0, 0, 5, 1'b0);         // plain main access
      run("R3", 2, 64, 1'b0, 2040, 12, 1'b0);     // spill into spare
      run("R7", 2, 64, 1'b0, 2048 + 10, 12, 1'b0);// buffer 0 to 1
      run("R4", 2, 64, 1'b0, 2048 + 20, 3, 1'b0); // column past page
      run("R5", 0, 16, 1'b1, 5, 3, 1'b0);         // spare-only, 512 page
      run("R5", 2, 64, 1'b1, 40, 4, 1'b0);        // spare-only, buffer 2
      run("R8", 2, 218, 1'b0, 2048 + 160, 58, 1'b0); // remainder in buffer 3
      run("R6", 3, 128, 1'b0, 4096 + 100, 20, 1'b0); // 8 buffers
      run("R6", 3, 8, 1'b1, 3, 2, 1'b0);          // zero share -> last buffer
      run("R6", 1, 33, 1'b1, 0, 33, 1'b0);        // odd spare, 2 buffers
      run("R9", 2, 64, 1'b0, 100, 0, 1'b0);       // zero length
      run("R10", 2, 64, 1'b0, 300, 12, 1'b1);     // start while busy

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule